// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for an Ethernet PHY on the management side. A host issues single read or write requests, each carrying a 5-bit PHY address, a register index and 16 bits of write data. Exactly one PHY answers, at the address set by a parameter. Requests to any other address read as all ones, and writes to them are dropped.

Most registers are plain storage. The status, link-partner and diagnostic registers are computed when they are read, from the `link_up` input and the local advertisement register (index 4). Negotiation therefore always appears to have finished in the best mode that was advertised. Bit 15 of the control register (index 0) is the soft-reset bit. It is cleared after every accepted write, so it never stays set.

A small state machine sequences each request. In `ST_IDLE` the block is ready. An accepted read takes transition IDLE→READ, and `ST_READ` presents the response for one cycle before READ→IDLE. An accepted write takes transition IDLE→WRITE, and `ST_WRITE` commits the store and the reset-bit clear before WRITE→IDLE. With no request, IDLE→IDLE holds.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, with the PHY's own address, index 0 reads 0x3100, index 2 reads 0x0300, index 3 reads 0xE400 and index 4 reads 0x01E1.
- R2: Index 1 reads 0x782E while `link_up` is 1 (bits 14, 13, 12, 11, 5, 3, 2 and 1 set) and 0x0000 while `link_up` is 0.
- R3: Index 5 reads 0x4000 OR (index-4 value AND 0x01E0) OR 0x0001, whatever the link state.
- R4: Index 17 always reads 0x8000.
- R5: While `link_up` is 1, index 18 reads bit 10 = (index-4 bit 7 OR bit 8) and bit 11 = (index-4 bit 8 OR bit 6), with all other bits 0. While `link_up` is 0 it reads 0x0000.
- R6: A write to the PHY's own address stores the data, and any index that is not 1, 5, 17 or 18 then reads back the stored value.
- R7: Every accepted write to the own address leaves bit 15 of index 0 cleared. Writing 0xB100 to index 0 reads back as 0x3100.
- R8: A read to any PHY address other than `PHY_ADDR` returns 0xFFFF. A write to such an address changes no register.
- R9: `req_ready` is 1 only in the idle state. A read accepted at a clock edge gives `rsp_valid` = 1 for exactly the next cycle. A write never raises `rsp_valid`. `req_ready` is 0 for the cycle after any acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state used by the computed status registers |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | REG_AW | Register index |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 16 | Read response data |

## Verification
The bench builds the block with `PHY_ADDR` = 9 rather than the default of 7. This means the default address, 0 and 31 can all be probed as foreign addresses, and a decoder with a hard-wired address would be caught. `REG_AW` stays at 5, which covers indices 17, 18 and 31. Several advertisement values are written to index 4 so that each term of the partner and diagnostic formulas is toggled on its own, with the link both up and down.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int DW = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } mgmt_state_e;

    localparam int IDX_CTRL    = 0;
    localparam int IDX_STAT    = 1;
    localparam int IDX_ID_HI   = 2;
    localparam int IDX_ID_LO   = 3;
    localparam int IDX_ADV     = 4;
    localparam int IDX_PARTNER = 5;
    localparam int IDX_SPEED   = 17;
    localparam int IDX_DIAG    = 18;

    localparam logic [DW-1:0] STAT_LINK_UP = 16'h782E;
    localparam logic [DW-1:0] SPEED_GIG    = 16'h8000;
    localparam logic [DW-1:0] NO_DEVICE    = 16'hFFFF;
    localparam logic [DW-1:0] ADV_MODES    = 16'h01E0;
    localparam int            CTRL_RST_BIT = 15;

    function automatic logic [DW-1:0] reset_value(int idx);
        case (idx)
            IDX_CTRL:  return 16'h3100;
            IDX_ID_HI: return 16'h0300;
            IDX_ID_LO: return 16'hE400;
            IDX_ADV:   return 16'h01E1;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/phy_mgmt_fsm.sv
module phy_mgmt_fsm
    import phy_mgmt_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_own,
    input  logic [REG_AW-1:0] req_reg,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              wr_en,
    output logic              hold_own,
    output logic [REG_AW-1:0] hold_reg,
    output logic [DW-1:0]     hold_wdata
);
    mgmt_state_e state_q, state_d;
    logic        accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = req_write ? ST_WRITE : ST_READ;
            ST_READ:  state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_own   <= 1'b0;
            hold_reg   <= '0;
            hold_wdata <= '0;
        end else if (accept) begin
            hold_own   <= req_own;
            hold_reg   <= req_reg;
            hold_wdata <= req_wdata;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        wr_en     = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_READ:  rsp_valid = 1'b1;
            ST_WRITE: wr_en     = hold_own;
            default:  ;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_store.sv
module phy_mgmt_store
    import phy_mgmt_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     stored,
    output logic [DW-1:0]     adv_q,
    output logic [DW-1:0]     ctrl_q
);
    localparam int NUM_REGS = 1 << REG_AW;

    logic [DW-1:0] mem_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= reset_value(i);
        end else if (wr_en) begin
            mem_q[idx] <= wdata;
            mem_q[IDX_CTRL][CTRL_RST_BIT] <= 1'b0;
        end
    end

    assign stored = mem_q[idx];
    assign adv_q  = mem_q[IDX_ADV];
    assign ctrl_q = mem_q[IDX_CTRL];
endmodule

// File: rtl/phy_mgmt_readmux.sv
module phy_mgmt_readmux
    import phy_mgmt_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              own,
    input  logic              link_up,
    input  logic [REG_AW-1:0] idx,
    input  logic [DW-1:0]     stored,
    input  logic [DW-1:0]     adv_q,
    output logic [DW-1:0]     rdata
);
    logic fast_mode, full_duplex;

    assign fast_mode   = adv_q[7] | adv_q[8];
    assign full_duplex = adv_q[8] | adv_q[6];

    always_comb begin
        rdata = stored;
        if (!own) begin
            rdata = NO_DEVICE;
        end else begin
            case (int'(idx))
                IDX_STAT:    rdata = link_up ? STAT_LINK_UP : '0;
                IDX_PARTNER: rdata = 16'h4000 | (adv_q & ADV_MODES) | 16'h0001;
                IDX_SPEED:   rdata = SPEED_GIG;
                IDX_DIAG: begin
                    rdata = '0;
                    if (link_up) begin
                        rdata[10] = fast_mode;
                        rdata[11] = full_duplex;
                    end
                end
                default:     rdata = stored;
            endcase
        end
    end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd7,
    parameter int         REG_AW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [4:0]        req_phy,
    input  logic [REG_AW-1:0] req_reg,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata
);
    logic              wr_en, hold_own;
    logic [REG_AW-1:0] hold_reg;
    logic [DW-1:0]     hold_wdata, stored, adv_q, ctrl_q, mux_data;

    phy_mgmt_fsm #(.REG_AW(REG_AW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_own(req_phy == PHY_ADDR), .req_reg(req_reg), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .wr_en(wr_en),
        .hold_own(hold_own), .hold_reg(hold_reg), .hold_wdata(hold_wdata)
    );

    phy_mgmt_store #(.REG_AW(REG_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(hold_reg),
        .wdata(hold_wdata), .stored(stored), .adv_q(adv_q), .ctrl_q(ctrl_q)
    );

    phy_mgmt_readmux #(.REG_AW(REG_AW)) u_mux (
        .own(hold_own), .link_up(link_up), .idx(hold_reg),
        .stored(stored), .adv_q(adv_q), .rdata(mux_data)
    );

    assign rsp_rdata = rsp_valid ? mux_data : '0;
endmodule

// File: rtl/phy_mgmt_regfile_checker.sv
module phy_mgmt_regfile_checker #(
    parameter logic [4:0] PHY_ADDR = 5'd7,
    parameter int         REG_AW   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_up,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [4:0]        req_phy,
    input logic [REG_AW-1:0] req_reg,
    input logic              rsp_valid,
    input logic [15:0]       rsp_rdata,
    input logic [15:0]       ctrl_q
);
    logic acc_rd, acc_wr, own;
    assign acc_rd = req_valid && req_ready && !req_write;
    assign acc_wr = req_valid && req_ready && req_write;
    assign own    = (req_phy == PHY_ADDR);

    a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rsp_valid);
    a_r9_no_rsp_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !rsp_valid);
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd || acc_wr) |=> !req_ready);
    a_r9_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r8_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !own) |=> (rsp_rdata == 16'hFFFF));
    a_r4_gig_speed: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && own && (int'(req_reg) == 17)) |=> (rsp_rdata == 16'h8000));
    a_r2_link_down_status: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && own && (int'(req_reg) == 1)) |=> (link_up || rsp_rdata == 16'h0000));
    a_r7_reset_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && own) |=> ##1 !ctrl_q[15]);
endmodule

bind phy_mgmt_regfile phy_mgmt_regfile_checker #(.PHY_ADDR(PHY_ADDR), .REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ctrl_q(ctrl_q)
);

// File: tb/phy_mgmt_regfile_test.sv
module phy_mgmt_regfile_test;
    localparam logic [4:0] OWN = 5'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    phy_mgmt_regfile #(.PHY_ADDR(OWN), .REG_AW(5)) uut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    // Read: present at negedge, accepted at next posedge, response sampled at following negedge.
    task automatic rd(input logic [4:0] phy, input logic [4:0] idx, output logic [15:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = phy; req_reg = idx;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 rsp_valid after read", {15'd0, rsp_valid}, 16'd1);
        check("R9 ready low while responding", {15'd0, req_ready}, 16'd0);
        data = rsp_rdata;
        @(negedge clk);
        check("R9 response lasts one cycle", {15'd0, rsp_valid}, 16'd0);
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] idx, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_phy = phy; req_reg = idx; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 no response to write", {15'd0, rsp_valid}, 16'd0);
        check("R9 ready low after write accept", {15'd0, req_ready}, 16'd0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R9 ready in idle", {15'd0, req_ready}, 16'd1);
        rd(OWN, 5'd0, d); check("R1 index 0", d, 16'h3100);
        rd(OWN, 5'd2, d); check("R1 index 2", d, 16'h0300);
        rd(OWN, 5'd3, d); check("R1 index 3", d, 16'hE400);
        rd(OWN, 5'd4, d); check("R1 index 4", d, 16'h01E1);
    endtask

    task automatic t_status();
        logic [15:0] d;
        link_up = 1'b1;
        rd(OWN, 5'd1, d);  check("R2 status link up", d, 16'h782E);
        rd(OWN, 5'd18, d); check("R5 diag reset adv", d, 16'h0C00);
        link_up = 1'b0;
        rd(OWN, 5'd1, d);  check("R2 status link down", d, 16'h0000);
        rd(OWN, 5'd18, d); check("R5 diag link down", d, 16'h0000);
        rd(OWN, 5'd5, d);  check("R3 partner link down", d, 16'h41E1);
        rd(OWN, 5'd17, d); check("R4 speed link down", d, 16'h8000);
        link_up = 1'b1;
        rd(OWN, 5'd17, d); check("R4 speed link up", d, 16'h8000);
    endtask

    task automatic t_adv();
        logic [15:0] d;
        wr(OWN, 5'd4, 16'h0040);
        rd(OWN, 5'd5, d);  check("R3 partner 10 full", d, 16'h4041);
        rd(OWN, 5'd18, d); check("R5 diag 10 full", d, 16'h0800);
        wr(OWN, 5'd4, 16'h0080);
        rd(OWN, 5'd5, d);  check("R3 partner 100 half", d, 16'h4081);
        rd(OWN, 5'd18, d); check("R5 diag 100 half", d, 16'h0400);
        wr(OWN, 5'd4, 16'h0020);
        rd(OWN, 5'd5, d);  check("R3 partner 10 half", d, 16'h4021);
        rd(OWN, 5'd18, d); check("R5 diag 10 half", d, 16'h0000);
        wr(OWN, 5'd4, 16'h0100);
        rd(OWN, 5'd18, d); check("R5 diag 100 full", d, 16'h0C00);
        wr(OWN, 5'd4, 16'hFFFF);
        rd(OWN, 5'd5, d);  check("R3 partner all bits", d, 16'h41E1);
        rd(OWN, 5'd4, d);  check("R6 adv readback", d, 16'hFFFF);
    endtask

    task automatic t_plain();
        logic [15:0] d;
        wr(OWN, 5'd9, 16'hA5C3);
        wr(OWN, 5'd31, 16'h1234);
        rd(OWN, 5'd9, d);  check("R6 index 9 readback", d, 16'hA5C3);
        rd(OWN, 5'd31, d); check("R6 index 31 readback", d, 16'h1234);
        rd(OWN, 5'd6, d);  check("R6 untouched index 6", d, 16'h0000);
    endtask

    task automatic t_rstbit();
        logic [15:0] d;
        wr(OWN, 5'd0, 16'hB100);
        rd(OWN, 5'd0, d); check("R7 reset bit self clears", d, 16'h3100);
        wr(OWN, 5'd0, 16'h8000);
        wr(OWN, 5'd12, 16'h0001);
        rd(OWN, 5'd0, d); check("R7 bit 15 clear after other write", d, 16'h0000);
    endtask

    task automatic t_foreign();
        logic [15:0] d;
        rd(5'd7, 5'd2, d);  check("R8 foreign read addr 7", d, 16'hFFFF);
        rd(5'd0, 5'd17, d); check("R8 foreign read addr 0", d, 16'hFFFF);
        rd(5'd31, 5'd1, d); check("R8 foreign read addr 31", d, 16'hFFFF);
        wr(5'd7, 5'd9, 16'h0BAD);
        wr(5'd8, 5'd0, 16'hFFFF);
        rd(OWN, 5'd9, d); check("R8 foreign write ignored index 9", d, 16'hA5C3);
        rd(OWN, 5'd0, d); check("R8 foreign write ignored index 0", d, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status();
        t_adv();
        t_plain();
        t_rstbit();
        t_foreign();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule